// File: doc/BRIEF.md
# Frequency Synthesiser Configuration Register with Lock Timer

This block is one memory-mapped control word for a frequency-synthesis loop. It has a bias-coded feedback multiplier field, a bias-coded reference pre-divider field and a coded post-divider field. It also has a pass-through (bypass) bit, a power bit and two read-only flags: lock and configuration error. From the stored fields it presents decoded divider values to an analog macro, together with a two-bit operating mode. The synthesised rate is reference × MUL / (PRE × POST). With pass-through set, the reference goes straight through. With the power bit clear, the output is off.

The analog loop is not modelled. A digital timer stands in for it. After any write that changes a divider field or the power bit, the lock flag drops. It rises again only once the power bit has stayed high for a set number of reference cycles. Software writes a new setting with pass-through clear and power set, then polls the lock flag. It should choose the pre-divider so that the reference divided by it lies between 10 and 50 MHz.

Top module: `pll_ctrl_reg`

## Requirements
- R1: After a cycle with rst_n low, the register holds pass-through=1, power=0, lock=0, error=0, MUL and PRE fields 0, and post-divider code 1. The outputs then show pll_mode=1 (pass-through), eff_mult=M_OFS, eff_ndiv=N_OFS and eff_odiv=1.
- R2: eff_mult equals the stored MUL field (bits [6:0]) plus M_OFS. eff_ndiv equals the stored PRE field (bits [12:8]) plus N_OFS. Both follow a write from the next clock edge.
- R3: The post-divider code (bits [18:16]) for table slot k is 2k+1, for k from 0 to OD_MAX-1. Writing a valid code sets eff_odiv to k+1.
- R4: Writing a code that is not in the table (any even code) sets the error flag (bit 27). The flag stays set until reset, and eff_odiv keeps its previous value.
- R5: pll_mode encodes the state as 0 off, 1 pass-through, 2 locking, 3 locked. Pass-through (bit 24) gives 1 whatever the other bits hold. Otherwise, power (bit 25) clear gives 0. Otherwise the mode is 2 while lock is low and 3 once lock is high.
- R6: After a write that sets power=1 and changes the setting, the lock flag (bit 26) reads 1 exactly LOCK_CYCLES clock edges after that write edge, provided no further change intervenes.
- R7: A write that changes MUL, PRE, the post-divider code or power clears lock and restarts the timer. A write that changes only pass-through, or changes nothing, leaves lock and the timer untouched.
- R8: While power is 0, lock reads 0.
- R9: Read data returns the fields at the positions given above, with all other bits 0. Data written to bit 26 (lock) and bit 27 (error) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read-back of the control word |
| eff_mult | output | 8 | Decoded feedback multiplier |
| eff_ndiv | output | 6 | Decoded reference pre-divider |
| eff_odiv | output | 3 | Decoded post-divider |
| pll_mode | output | 2 | 0 off, 1 pass-through, 2 locking, 3 locked |
| pll_stable | output | 1 | Lock flag |
| cfg_err | output | 1 | Sticky invalid post-divider code flag |

## Verification
The bench rewrites an identical word and a word that changes only pass-through. A design that compared the whole word would drop lock on those writes. It also rewrites the setting halfway through the lock wait, where a timer that failed to restart would announce lock too early. It writes an even post-divider code to catch a decoder that lets the divider follow an unlisted code or forgets the error. It also pushes all-ones into the read-only lock and error bits and uses maximum field values, where a wrong bias adder would show up.

// File: rtl/pll_ctrl_pkg.sv
// Shared types and bit positions for the synthesiser control word.
// Assumes every field fits in eight bits at its fixed position.
package pll_ctrl_pkg;
    typedef enum logic [1:0] {
        MODE_OFF     = 2'd0,
        MODE_BYPASS  = 2'd1,
        MODE_LOCKING = 2'd2,
        MODE_LOCKED  = 2'd3
    } pll_mode_e;

    localparam int MUL_LSB = 0;
    localparam int DIV_LSB = 8;
    localparam int ODC_LSB = 16;
    localparam int BYP_BIT = 24;
    localparam int EN_BIT  = 25;
    localparam int STB_BIT = 26;
    localparam int ERR_BIT = 27;
endpackage

// File: rtl/pll_od_decode.sv
// Post-divider code decoder: table slot k holds code 2k+1, divider is k+1.
// Assumes 2*(OD_MAX-1)+1 fits in OD_BITS. Purely combinational.
module pll_od_decode #(
    parameter int OD_BITS = 3,
    parameter int OD_MAX  = 4,
    parameter int OD_W    = 3
) (
    input  logic [OD_BITS-1:0] code,
    output logic               valid,
    output logic [OD_W-1:0]    odiv
);
    logic [OD_MAX-1:0] hit;

    // one comparator per table slot
    for (genvar k = 0; k < OD_MAX; k++) begin : g_slot
        assign hit[k] = (code == OD_BITS'(2 * k + 1));
    end

    // pick the divider of the matching slot
    always_comb begin
        valid = |hit;
        odiv  = '0;
        for (int k = 0; k < OD_MAX; k++) begin
            if (hit[k]) odiv = OD_W'(k + 1);
        end
    end
endmodule

// File: rtl/pll_lock_timer.sv
// Lock stand-in: counts cycles with power held high after a restart and
// raises the lock flag after LOCK_CYCLES edges. Synchronous active-low reset.
module pll_lock_timer #(
    parameter int LOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic enable,
    output logic stable
);
    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);
    logic [CNT_W-1:0] cnt;

    // advance the count toward the lock point, clear on restart or power-off
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !enable) begin
            cnt    <= '0;
            stable <= 1'b0;
        end else if (cnt != CNT_W'(LOCK_CYCLES)) begin
            cnt    <= cnt + 1'b1;
            stable <= (cnt == CNT_W'(LOCK_CYCLES - 1));
        end
    end
endmodule

// File: rtl/pll_ctrl_reg.sv
// Control/status word for a frequency-synthesis loop. Holds bias-coded
// dividers, a coded post-divider, pass-through and power bits, and read-only
// lock and error flags. Assumes fields fit the package bit positions.
module pll_ctrl_reg
    import pll_ctrl_pkg::*;
#(
    parameter int M_BITS      = 7,
    parameter int N_BITS      = 5,
    parameter int OD_BITS     = 3,
    parameter int OD_MAX      = 4,
    parameter int M_OFS       = 2,
    parameter int N_OFS       = 2,
    parameter int LOCK_CYCLES = 64,
    parameter int DATA_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [M_BITS:0]   eff_mult,
    output logic [N_BITS:0]   eff_ndiv,
    output logic [2:0]        eff_odiv,
    output logic [1:0]        pll_mode,
    output logic              pll_stable,
    output logic              cfg_err
);
    localparam int OD_W = 3;

    logic [M_BITS-1:0]  mul_q;
    logic [N_BITS-1:0]  div_q;
    logic [OD_BITS-1:0] odc_q;
    logic               byp_q, en_q, err_q;
    logic [OD_W-1:0]    od_q;

    logic [M_BITS-1:0]  w_mul;
    logic [N_BITS-1:0]  w_div;
    logic [OD_BITS-1:0] w_odc;
    logic               w_en, w_valid, cfg_change, stb;
    logic [OD_W-1:0]    w_od;

    // slice the incoming write word
    always_comb begin
        w_mul = wr_data[MUL_LSB +: M_BITS];
        w_div = wr_data[DIV_LSB +: N_BITS];
        w_odc = wr_data[ODC_LSB +: OD_BITS];
        w_en  = wr_data[EN_BIT];
        cfg_change = wr_en && ((w_mul != mul_q) || (w_div != div_q) ||
                               (w_odc != odc_q) || (w_en != en_q));
    end

    pll_od_decode #(.OD_BITS(OD_BITS), .OD_MAX(OD_MAX), .OD_W(OD_W)) u_dec (
        .code  (w_odc),
        .valid (w_valid),
        .odiv  (w_od)
    );

    // register update on write, sticky error on unlisted code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mul_q <= '0;
            div_q <= '0;
            odc_q <= OD_BITS'(1);
            byp_q <= 1'b1;
            en_q  <= 1'b0;
            err_q <= 1'b0;
            od_q  <= OD_W'(1);
        end else if (wr_en) begin
            mul_q <= w_mul;
            div_q <= w_div;
            odc_q <= w_odc;
            byp_q <= wr_data[BYP_BIT];
            en_q  <= w_en;
            if (w_valid) od_q  <= w_od;
            else         err_q <= 1'b1;
        end
    end

    pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_change),
        .enable  (en_q),
        .stable  (stb)
    );

    // mode, decoded values and read-back
    always_comb begin
        pll_mode_e m;
        if (byp_q)      m = MODE_BYPASS;
        else if (!en_q) m = MODE_OFF;
        else if (stb)   m = MODE_LOCKED;
        else            m = MODE_LOCKING;
        pll_mode   = m;
        pll_stable = stb;
        cfg_err    = err_q;
        eff_mult   = {1'b0, mul_q} + (M_BITS+1)'(M_OFS);
        eff_ndiv   = {1'b0, div_q} + (N_BITS+1)'(N_OFS);
        eff_odiv   = od_q;
        rd_data    = '0;
        rd_data[MUL_LSB +: M_BITS]  = mul_q;
        rd_data[DIV_LSB +: N_BITS]  = div_q;
        rd_data[ODC_LSB +: OD_BITS] = odc_q;
        rd_data[BYP_BIT] = byp_q;
        rd_data[EN_BIT]  = en_q;
        rd_data[STB_BIT] = stb;
        rd_data[ERR_BIT] = err_q;
    end
endmodule

// File: rtl/pll_ctrl_reg_chk.sv
// Property checker for pll_ctrl_reg, attached by bind below.
module pll_ctrl_reg_chk
    import pll_ctrl_pkg::*;
#(
    parameter int M_BITS = 7,
    parameter int N_BITS = 5,
    parameter int OD_BITS = 3,
    parameter int M_OFS  = 2,
    parameter int N_OFS  = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [M_BITS:0]   eff_mult,
    input logic [N_BITS:0]   eff_ndiv,
    input logic [1:0]        pll_mode,
    input logic              pll_stable,
    input logic              cfg_err
);
    logic chg;
    // detect a configuration-changing write from the ports
    always_comb begin
        chg = wr_en && ((wr_data[MUL_LSB +: M_BITS] != rd_data[MUL_LSB +: M_BITS]) ||
                        (wr_data[DIV_LSB +: N_BITS] != rd_data[DIV_LSB +: N_BITS]) ||
                        (wr_data[ODC_LSB +: OD_BITS] != rd_data[ODC_LSB +: OD_BITS]) ||
                        (wr_data[EN_BIT] != rd_data[EN_BIT]));
    end

    a_r2_mult_bias: assert property (@(posedge clk) disable iff (!rst_n)
        eff_mult == {1'b0, rd_data[MUL_LSB +: M_BITS]} + (M_BITS+1)'(M_OFS));
    a_r2_div_bias: assert property (@(posedge clk) disable iff (!rst_n)
        eff_ndiv == {1'b0, rd_data[DIV_LSB +: N_BITS]} + (N_BITS+1)'(N_OFS));
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
    a_r5_bypass_mode: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BYP_BIT] |-> pll_mode == 2'd1);
    a_r7_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !pll_stable);
    a_r8_off_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[EN_BIT] |-> !pll_stable);
    a_r6_rise_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_stable) |-> rd_data[EN_BIT]);
endmodule

bind pll_ctrl_reg pll_ctrl_reg_chk #(
    .M_BITS(M_BITS), .N_BITS(N_BITS), .OD_BITS(OD_BITS),
    .M_OFS(M_OFS), .N_OFS(N_OFS), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .eff_mult(eff_mult), .eff_ndiv(eff_ndiv),
    .pll_mode(pll_mode), .pll_stable(pll_stable), .cfg_err(cfg_err)
);

// File: tb/sim_pll_ctrl_reg.sv
module sim_pll_ctrl_reg;
    localparam int LOCK = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  eff_mult;
    logic [5:0]  eff_ndiv;
    logic [2:0]  eff_odiv;
    logic [1:0]  pll_mode;
    logic        pll_stable, cfg_err;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit running = 0;

    pll_ctrl_reg #(.LOCK_CYCLES(LOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .eff_mult(eff_mult), .eff_ndiv(eff_ndiv),
        .eff_odiv(eff_odiv), .pll_mode(pll_mode), .pll_stable(pll_stable),
        .cfg_err(cfg_err)
    );

    always #4 clk = ~clk;

    // behavioural model state
    int mf, nf, odc, byp, en, stb, cnt, err, odv;

    function automatic int code_ok(int c);
        return (c % 2 == 1) && (c / 2 < 4);
    endfunction

    // model update on each rising edge
    always @(posedge clk) begin
        int wm, wn, wo, we;
        bit change;
        if (!rst_n) begin
            mf = 0; nf = 0; odc = 1; byp = 1; en = 0; stb = 0; cnt = 0; err = 0; odv = 1;
        end else begin
            change = 0;
            if (wr_en) begin
                wm = wr_data[6:0]; wn = wr_data[12:8]; wo = wr_data[18:16]; we = wr_data[25];
                change = (wm != mf) || (wn != nf) || (wo != odc) || (we != en);
                mf = wm; nf = wn; odc = wo; en = we; byp = wr_data[24];
                if (code_ok(wo) != 0) odv = wo / 2 + 1; else err = 1;
            end
            if (change || en == 0) begin
                cnt = 0; stb = 0;
            end else if (cnt < LOCK) begin
                cnt++;
                if (cnt == LOCK) stb = 1;
            end
        end
    end

    task automatic cmp(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cycles, act, exp);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        int em;
        if (running) begin
            cycles++;
            if (byp != 0) em = 1; else if (en == 0) em = 0; else if (stb != 0) em = 3; else em = 2;
            cmp("R9 read-back (R1)", rd_data,
                {4'b0, err[0], stb[0], en[0], byp[0], 5'b0, odc[2:0], 3'b0, nf[4:0], 1'b0, mf[6:0]});
            cmp("R2 eff_mult", eff_mult, mf + 2);
            cmp("R2 eff_ndiv", eff_ndiv, nf + 2);
            cmp("R3 R4 eff_odiv", eff_odiv, odv);
            cmp("R5 pll_mode", pll_mode, em);
            cmp("R6 R7 R8 pll_stable", pll_stable, stb);
            cmp("R4 cfg_err", cfg_err, err);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input int m, input int n, input int oc, input bit b, input bit e,
                      input bit junk);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = '0;
        wr_data[6:0] = 7'(m); wr_data[12:8] = 5'(n); wr_data[18:16] = 3'(oc);
        wr_data[24] = b; wr_data[25] = e;
        wr_data[26] = junk; wr_data[27] = junk;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // watchdog
    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        running = 1;
        @(negedge clk);
        rst_n = 1'b1;
        idle(3);
        // R2 R3 R6: program and wait for lock
        wr(10, 3, 3, 0, 1, 0);
        idle(LOCK + 5);
        // R7: identical rewrite and pass-through-only change keep lock
        wr(10, 3, 3, 0, 1, 0);
        idle(5);
        wr(10, 3, 3, 1, 1, 0);
        idle(5);
        // R9 R7: junk in read-only bits, multiplier change drops lock
        wr(20, 3, 3, 0, 1, 1);
        idle(30);
        // R7: rewrite mid-lock restarts the timer
        wr(20, 4, 5, 0, 1, 0);
        idle(LOCK + 3);
        // R4: unlisted code, divider holds, error sticks
        wr(20, 4, 2, 0, 1, 0);
        idle(10);
        wr(20, 4, 7, 0, 1, 0);
        idle(LOCK + 3);
        // R2 R3: extreme fields
        wr(127, 31, 1, 0, 1, 0);
        idle(10);
        // R8 R5: power off, then off with pass-through
        wr(127, 31, 1, 0, 0, 0);
        idle(LOCK + 3);
        wr(127, 31, 1, 1, 0, 0);
        idle(5);
        // R1: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(5);
        running = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule